// File: doc/BRIEF.md
# Three-Wire Serial Clock-Chip Register Master

This block is a hardware master for a clock chip that is reached over three wires: a chip-enable line, a serial clock and one bidirectional data line. Each access reads or writes one 4-bit register. A host hands over a request with a register address, a direction flag and a write nibble. The block clocks out an 8-bit command byte. A write then sends a second byte that carries the nibble. A read turns the data line around, clocks in eight bits and returns the low four. When the access completes, a response pulse carries the result.

Bit timing comes from a half-period counter. Its length is derived from the system clock frequency and a minimum half-period in nanoseconds, rounded up. The chip-enable output follows a separate request input, one clock later, so a caller can hold the chip selected across a whole series of accesses.

The request side is a valid/ready interface. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole access, and any request offered while it is low is ignored. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse and the consumer must capture `rsp_rdata` in that cycle.

Top module: `rtc3w_master`

## Requirements
- R1: The command byte of a read is `0 1 1 0 a3 a2 a1 a0` (bit 6 read flag, bit 5 address marker). The command byte of a write is `0 0 1 0 a3 a2 a1 a0`.
- R2: A write sends a second byte `0 0 0 1 d3 d2 d1 d0` (bit 4 data marker, bits 7..5 zero) right after its command byte. A read sends no second byte.
- R3: Every byte has exactly eight bits, sent most significant bit first. `sda_o` changes only while `scl` is high and is stable while `scl` is low.
- R4: `scl` is high whenever no access is in progress. Each bit has a high phase of HALF clocks followed by a low phase of HALF clocks, where HALF = ceil(CLK_HZ x HALF_NS / 1e9).
- R5: `sda_oe` rises one clock after the first bit of a sent byte is placed and stays high through that byte's eight low phases. It is low during a received byte and whenever the block is idle.
- R6: On a read, `sda_i` is sampled at the end of each bit's high phase, just before `scl` falls. `rsp_rdata` is the low four bits of the received byte, first bit received as bit 7; the upper four are discarded.
- R7: `req_ready` is high exactly when the block is idle. A request is accepted only on `req_valid && req_ready`, and requests offered while busy leave no trace on the wires or the response.
- R8: Each accepted request yields exactly one single-cycle `rsp_valid` pulse, in the cycle `busy` falls. It carries the read nibble, or zero for a write.
- R9: `ce` equals `ce_req` delayed by one clock, whether or not an access is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_req | input | 1 | Caller's chip-enable request |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 4 | Write nibble |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read nibble (zero after a write) |
| busy | output | 1 | Access in progress |
| ce | output | 1 | Chip enable to the clock chip |
| scl | output | 1 | Serial clock, idles high |
| sda_o | output | 1 | Serial data out value |
| sda_oe | output | 1 | Serial data driver enable |
| sda_i | input | 1 | Serial data in |

## Verification
The bench plays the clock chip. Its responses put a non-zero upper nibble next to the wanted low nibble, so a master that kept the wrong half of the read byte, or shifted it in LSB first, returns a wrong `rsp_rdata`. Every falling edge of `scl` is matched against an expected bit stream built from the address and flag layout, which exposes swapped marker bits, a second byte sent on a read, or a reversed bit order. The low phase of every bit is timed against the rounded-up half-period; a truncating division would give one clock less at the odd clock rate the bench uses. Requests are offered again in the middle of an access to show that a master which re-arms while busy corrupts the stream. `ce_req` is also toggled mid-access to show that chip enable is not tied to the transfer.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} phase_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_CMD, SQ_WDAT, SQ_RDAT} seq_t;

  // command byte: bit6 = read flag, bit5 = address marker
  function automatic logic [BYTE_W-1:0] cmd_byte(logic [NIB_W-1:0] a, logic rd);
    return {1'b0, rd, 1'b1, 1'b0, a};
  endfunction

  // data byte: bit4 = data marker
  function automatic logic [BYTE_W-1:0] data_byte(logic [NIB_W-1:0] d);
    return {3'b000, 1'b1, d};
  endfunction

  // clocks per half-period, rounded up so the minimum is always met
  function automatic int unsigned half_cycles(longint unsigned hz, longint unsigned ns);
    longint unsigned prod;
    prod = hz * ns;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction
endpackage

// File: rtl/rtc3w_halfper.sv
module rtc3w_halfper #(
  parameter int unsigned CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [W-1:0] cnt;

  assign tick = run && (cnt == W'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc3w_shifter.sv
module rtc3w_shifter
  import rtc3w_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              rx_mode,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sda_i,
  output logic              scl,
  output logic              sda_o,
  output logic              sda_oe,
  output logic [NIB_W-1:0]  rx_nib,
  output logic              fin
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);

  phase_t            ph;
  logic [IDX_W-1:0]  bit_idx;
  logic [BYTE_W-1:0] shreg;
  logic              rx_q;
  logic              tick;

  rtc3w_halfper #(.CYCLES(HALF_CYC)) u_half (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ph != PH_IDLE),
    .tick (tick)
  );

  assign rx_nib = shreg[NIB_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      bit_idx <= '0;
      shreg   <= '0;
      rx_q    <= 1'b0;
      scl     <= 1'b1;
      sda_o   <= 1'b0;
      sda_oe  <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (ph)
        PH_IDLE: if (go) begin
          ph      <= PH_HIGH;
          bit_idx <= '0;
          rx_q    <= rx_mode;
          shreg   <= tx_byte;
          sda_o   <= rx_mode ? 1'b0 : tx_byte[BYTE_W-1];
        end
        PH_HIGH: begin
          if (!rx_q) sda_oe <= 1'b1;   // driver on once the first bit is on the line
          if (tick) begin
            ph  <= PH_LOW;
            scl <= 1'b0;
            if (rx_q) shreg <= {shreg[BYTE_W-2:0], sda_i};
          end
        end
        PH_LOW: if (tick) begin
          scl <= 1'b1;
          if (bit_idx == IDX_W'(BYTE_W - 1)) begin
            ph     <= PH_IDLE;
            fin    <= 1'b1;
            sda_oe <= 1'b0;
            sda_o  <= 1'b0;
          end else begin
            ph      <= PH_HIGH;
            bit_idx <= bit_idx + 1'b1;
            if (!rx_q) begin
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
              sda_o <= shreg[BYTE_W-2];
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master
  import rtc3w_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 100_000_000,
  parameter longint unsigned HALF_NS = 700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_req,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [NIB_W-1:0] req_addr,
  input  logic [NIB_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [NIB_W-1:0] rsp_rdata,
  output logic             busy,
  output logic             ce,
  output logic             scl,
  output logic             sda_o,
  output logic             sda_oe,
  input  logic             sda_i
);
  localparam int unsigned HALF_RAW = half_cycles(CLK_HZ, HALF_NS);
  localparam int unsigned HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

  seq_t              sq;
  logic              wr_q;
  logic [BYTE_W-1:0] dat_q;
  logic              go;
  logic              rx_mode;
  logic [BYTE_W-1:0] tx_byte;
  logic              fin;
  logic [NIB_W-1:0]  rx_nib;

  rtc3w_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .rx_mode(rx_mode),
    .tx_byte(tx_byte),
    .sda_i  (sda_i),
    .scl    (scl),
    .sda_o  (sda_o),
    .sda_oe (sda_oe),
    .rx_nib (rx_nib),
    .fin    (fin)
  );

  assign busy      = (sq != SQ_IDLE);
  assign req_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq        <= SQ_IDLE;
      wr_q      <= 1'b0;
      dat_q     <= '0;
      go        <= 1'b0;
      rx_mode   <= 1'b0;
      tx_byte   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ce        <= 1'b0;
    end else begin
      go        <= 1'b0;
      rsp_valid <= 1'b0;
      ce        <= ce_req;
      unique case (sq)
        SQ_IDLE: if (req_valid) begin
          sq      <= SQ_CMD;
          go      <= 1'b1;
          rx_mode <= 1'b0;
          tx_byte <= cmd_byte(req_addr, !req_write);
          wr_q    <= req_write;
          dat_q   <= data_byte(req_wdata);
        end
        SQ_CMD: if (fin) begin
          go <= 1'b1;
          if (wr_q) begin
            sq      <= SQ_WDAT;
            rx_mode <= 1'b0;
            tx_byte <= dat_q;
          end else begin
            sq      <= SQ_RDAT;
            rx_mode <= 1'b1;
          end
        end
        SQ_WDAT: if (fin) begin
          sq        <= SQ_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= '0;
        end
        SQ_RDAT: if (fin) begin
          sq        <= SQ_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= rx_nib;
        end
        default: sq <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc3w_master_chk.sv
module rtc3w_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic scl,
  input logic sda_o,
  input logic sda_oe,
  input logic ce,
  input logic ce_req
);
  p_oe_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe);

  p_scl_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> scl);

  p_sda_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !scl) |-> $stable(sda_o));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);

  p_ce_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ce == $past(ce_req)));
endmodule

bind rtc3w_master rtc3w_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .scl      (scl),
  .sda_o    (sda_o),
  .sda_oe   (sda_oe),
  .ce       (ce),
  .ce_req   (ce_req)
);

// File: tb/rtc3w_master_test.sv
`timescale 1ns/1ps
module rtc3w_master_test;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned CLK_HZ = 15_000_000;   // odd rate: 10.5 -> 11
  localparam int EXP_HALF = int'((CLK_HZ * 700 + 999_999_999) / 1_000_000_000);
  localparam int LIMIT = 150_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_req = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, busy, ce, scl, sda_o, sda_oe;
  logic [3:0] rsp_rdata;
  logic sda_i = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc3w_master #(.CLK_HZ(CLK_HZ), .HALF_NS(700)) uut (
    .clk(clk), .rst_n(rst_n), .ce_req(ce_req), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .busy(busy), .ce(ce), .scl(scl), .sda_o(sda_o), .sda_oe(sda_oe),
    .sda_i(sda_i));

  int errors = 0, checks = 0, rsp_count = 0;
  bit finished = 1'b0;

  // reference model state
  int  exp_bits[$];   // 0/1 = sent bit, 2 = received slot
  int  exp_tag[$];    // requirement number for that bit
  int  slave_bits[$];
  int  exp_rd[$];
  bit  model_busy = 1'b0;
  logic [7:0] slave_byte = 8'h00;
  logic prev_scl = 1'b1, prev_ce_req = 1'b0;
  int  low_cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_byte(input logic [7:0] b, input int tag);
    for (int i = 7; i >= 0; i--) begin
      exp_bits.push_back(int'(b[i]));
      exp_tag.push_back(tag);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_scl = 1'b1;
      prev_ce_req = ce_req;
    end else begin
      chk(ce == prev_ce_req, "R9 ce", int'(ce), int'(prev_ce_req));
      prev_ce_req = ce_req;

      if (rsp_valid) begin
        int e;
        e = (exp_rd.size() > 0) ? exp_rd.pop_front() : -1;
        chk(int'(rsp_rdata) == e, "R6/R8 rsp_rdata", int'(rsp_rdata), e);
        chk(exp_bits.size() == 0, "R3/R2 bits left at response", exp_bits.size(), 0);
        model_busy = 1'b0;
        rsp_count++;
      end

      chk(req_ready == !model_busy, "R7 req_ready", int'(req_ready), int'(!model_busy));
      if (!model_busy) begin
        chk(scl == 1'b1, "R4 scl idle", int'(scl), 1);
        chk(sda_oe == 1'b0, "R5 oe idle", int'(sda_oe), 0);
      end

      if (!scl) low_cnt++;
      if (!prev_scl && scl) begin
        chk(low_cnt == EXP_HALF, "R4 low phase length", low_cnt, EXP_HALF);
        low_cnt = 0;
      end

      if (prev_scl && !scl) begin
        if (exp_bits.size() == 0) begin
          chk(1'b0, "R3 unexpected bit", 1, 0);
        end else begin
          int b, t;
          b = exp_bits.pop_front();
          t = exp_tag.pop_front();
          if (b == 2) begin
            chk(sda_oe == 1'b0, "R5 oe during receive", int'(sda_oe), 0);
          end else begin
            chk(sda_oe == 1'b1, "R5 oe during send", int'(sda_oe), 1);
            chk(int'(sda_o) == b, (t == 1) ? "R1 command bit" : "R2 data bit",
                int'(sda_o), b);
          end
          if (exp_bits.size() > 0 && exp_bits[0] == 2 && slave_bits.size() > 0)
            sda_i = slave_bits.pop_front() != 0;
        end
      end
      prev_scl = scl;

      if (req_valid && !model_busy) begin
        model_busy = 1'b1;
        if (req_write) begin
          push_byte({4'b0010, req_addr}, 1);
          push_byte({4'b0001, req_wdata}, 2);
          exp_rd.push_back(0);
        end else begin
          push_byte({4'b0110, req_addr}, 1);
          for (int i = 7; i >= 0; i--) begin
            exp_bits.push_back(2);
            exp_tag.push_back(6);
            slave_bits.push_back(int'(slave_byte[i]));
          end
          exp_rd.push_back(int'(slave_byte[3:0]));
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [3:0] a, input logic [3:0] d,
                        input logic [7:0] sb, input bit poke);
    int c0;
    c0 = rsp_count;
    @(posedge clk); #1;
    slave_byte = sb;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (poke) begin
      // R7: offers while busy must be ignored
      repeat (3) @(posedge clk);
      #1;
      req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
      repeat (4) @(posedge clk);
      #1;
      req_valid = 1'b0;
    end
    while (rsp_count == c0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog (all) act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1;
    // reset state: R4 R5 R7 R8 R9
    chk(scl == 1'b1, "R4 reset scl", int'(scl), 1);
    chk(sda_oe == 1'b0, "R5 reset oe", int'(sda_oe), 0);
    chk(req_ready == 1'b1, "R7 reset ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R8 reset rsp_valid", int'(rsp_valid), 0);
    chk(ce == 1'b0, "R9 reset ce", int'(ce), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    ce_req = 1'b1;
    access(1'b1, 4'hE, 4'h4, 8'h00, 1'b0);   // R1 R2 write
    access(1'b0, 4'hE, 4'h0, 8'hA5, 1'b0);   // R6 read, junk upper nibble
    access(1'b1, 4'h7, 4'h0, 8'h00, 1'b0);   // R2 zero nibble
    access(1'b0, 4'h0, 4'h0, 8'h3C, 1'b1);   // R7 poke while busy
    access(1'b0, 4'hF, 4'h0, 8'hF0, 1'b0);   // R6 upper all ones discarded
    fork
      access(1'b1, 4'hF, 4'hF, 8'h00, 1'b1); // R7 poke on write
      begin
        repeat (40) @(posedge clk); #1; ce_req = 1'b0;   // R9 mid-access
        repeat (60) @(posedge clk); #1; ce_req = 1'b1;
      end
    join
    access(1'b0, 4'h9, 4'h0, 8'h5B, 1'b0);
    ce_req = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    chk(rsp_count == 7, "R8 one response per request", rsp_count, 7);
    chk(exp_rd.size() == 0, "R8 responses consumed", exp_rd.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule